// File: doc/BRIEF.md
# Auto-Incrementing Indirect Video Memory Port

This block lets a host reach a private video memory through only two host-visible locations. The control location (`host_sel_i = 0`) selects an internal register on a write and returns a status byte on a read. The status byte carries a ready flag. The data location (`host_sel_i = 1`) reads or writes whichever internal register is selected.

The internal registers are a 16-bit memory pointer, split into a high byte (index 18) and a low byte (index 19), and a memory data port (index 31). Each access to the data port moves one byte between the host and video memory at the pointer, then advances the pointer by one. The pointer wraps at the configured memory size. Because of this, a linear block transfer is a single register select followed by repeated data accesses, with no reload of the address.

Memory traffic goes through a simple request/grant slot interface, and the grant may arrive after any number of cycles. While a memory access is outstanding the ready flag is low. The host polls the status byte and does not wait for a fixed time.

Top module: `vram_port`

## Requirements
- R1: After reset the pointer is 0, the selected index is 0 and ready is 1, so a status read returns 0x80.
- R2: A host write to the control location stores `host_wdata_i[4:0]` as the selected index. A status read returns {ready in bit 7, bits 6:5 zero, index in bits 4:0} on `host_rdata_o`, registered on the same clock edge that samples `host_rd_i`.
- R3: Through the data location, index 18 accesses pointer bits 15:8 and index 19 accesses bits 7:0. Reads of these indexes return the current pointer halves. Any index other than 18, 19 and 31 reads 0, and writes to it are ignored.
- R4: Writing index 19 loads the low pointer byte, clears ready and requests a memory read at the new pointer. Ready returns in the cycle after the grant, and the byte read is then held in a read latch.
- R5: Reading index 31 returns the read latch. The same edge increments the pointer, and the block then requests a prefetch read at the incremented pointer, with ready low until the cycle after its grant.
- R6: Writing index 31 requests a memory write of the byte at the pointer. Ready stays low until the cycle after the grant, and from that cycle the pointer has advanced by one.
- R7: An increment from `MEM_DEPTH-1`, or from any larger value, gives 0.
- R8: While ready is 0, writes through the data location and reads of index 31 have no effect on the pointer, the memory or the read latch.
- R9: Once raised, `mem_req_o` stays high, with `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stable, until the cycle in which `mem_gnt_i` is high. It drops in the cycle after the grant.
- R10: Repeated index-31 accesses without any re-selection walk consecutive memory addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_i | input | 1 | 0 = control/status location, 1 = data location |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Registered host read data |
| mem_req_o | output | 1 | Memory slot request |
| mem_we_o | output | 1 | 1 = write access, 0 = read access |
| mem_addr_o | output | 2*DATA_W | Memory address (the pointer) |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_gnt_i | input | 1 | Slot grant; the access completes in this cycle |
| mem_rdata_i | input | DATA_W | Memory read data, valid in the grant cycle |

## Verification
Host read data appears on `host_rdata_o` one edge after the read strobe. A scoreboard monitor therefore pops its expected item at the falling edge that follows that edge. Ready falls on the edge that accepts a pointer-low write or a data access, so a status read issued in the very next cycle must show it low when the grant latency is at least one cycle. Ready rises one cycle after the grant, and the bench polls status before every dependent access. The bench memory model varies the grant latency between 0 and 3 cycles, and checks at each edge that an ungranted request held its address and data.

// File: rtl/vp_pkg.sv
package vp_pkg;
  localparam int IDX_PTR_HI = 18;
  localparam int IDX_PTR_LO = 19;
  localparam int IDX_DATA   = 31;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_WRITE,
    SEQ_READ
  } seq_state_e;
endpackage

// File: rtl/vp_host_decode.sv
module vp_host_decode #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              ld_hi_o,
  output logic              ld_lo_o,
  output logic              data_wr_o,
  output logic              data_rd_o
);
  import vp_pkg::*;

  logic [IDX_W-1:0] idx_q;
  logic             dwr, drd;
  logic             is_hi, is_lo, is_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           idx_q <= '0;
    else if (wr_i && !sel_i) idx_q <= wdata_i[IDX_W-1:0];
  end

  always_comb begin
    dwr     = wr_i && sel_i;
    drd     = rd_i && !wr_i && sel_i;
    is_hi   = (idx_q == IDX_W'(IDX_PTR_HI));
    is_lo   = (idx_q == IDX_W'(IDX_PTR_LO));
    is_data = (idx_q == IDX_W'(IDX_DATA));
    // pointer and data side effects only when no access is outstanding
    ld_hi_o   = dwr && is_hi && ready_i;
    ld_lo_o   = dwr && is_lo && ready_i;
    data_wr_o = dwr && is_data && ready_i;
    data_rd_o = drd && is_data && ready_i;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/vp_addr_ptr.sv
module vp_addr_ptr #(
  parameter int DATA_W    = 8,
  parameter int MEM_DEPTH = 16384
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_hi_i,
  input  logic                ld_lo_i,
  input  logic                inc_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [2*DATA_W-1:0] ptr_o
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(MEM_DEPTH - 1);

  logic [ADDR_W-1:0] ptr_q, ptr_inc;

  assign ptr_inc = (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (ld_hi_i) ptr_q[ADDR_W-1:DATA_W] <= wdata_i;
    else if (ld_lo_i) ptr_q[DATA_W-1:0] <= wdata_i;
    else if (inc_i)   ptr_q <= ptr_inc;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/vp_mem_seq.sv
module vp_mem_seq #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_wr_i,
  input  logic              start_rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mem_gnt_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              ready_o,
  output logic              wr_done_o,
  output logic [DATA_W-1:0] rd_latch_o
);
  import vp_pkg::*;

  seq_state_e        state_q, state_d;
  logic [DATA_W-1:0] wbuf_q, latch_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_wr_i)      state_d = SEQ_WRITE;
        else if (start_rd_i) state_d = SEQ_READ;
      end
      SEQ_WRITE, SEQ_READ: if (mem_gnt_i) state_d = SEQ_IDLE;
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      wbuf_q  <= '0;
      latch_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SEQ_IDLE && start_wr_i)  wbuf_q  <= wdata_i;
      if (state_q == SEQ_READ && mem_gnt_i)   latch_q <= mem_rdata_i;
    end
  end

  assign mem_req_o   = (state_q != SEQ_IDLE);
  assign mem_we_o    = (state_q == SEQ_WRITE);
  assign mem_wdata_o = wbuf_q;
  assign ready_o     = (state_q == SEQ_IDLE);
  assign wr_done_o   = (state_q == SEQ_WRITE) && mem_gnt_i;
  assign rd_latch_o  = latch_q;
endmodule

// File: rtl/vram_port.sv
module vram_port #(
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 5,
  parameter int MEM_DEPTH = 16384
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_sel_i,
  input  logic                host_wr_i,
  input  logic                host_rd_i,
  input  logic [DATA_W-1:0]   host_wdata_i,
  output logic [DATA_W-1:0]   host_rdata_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [2*DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic                mem_gnt_i,
  input  logic [DATA_W-1:0]   mem_rdata_i
);
  import vp_pkg::*;

  localparam int ADDR_W = 2 * DATA_W;
  localparam int PAD_W  = DATA_W - 1 - IDX_W;

  logic [IDX_W-1:0]  idx_q;
  logic              ready, ld_hi, ld_lo, data_wr, data_rd, wr_done;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] rd_latch, rd_mux, rdata_q;

  vp_host_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (host_sel_i),
    .wr_i     (host_wr_i),
    .rd_i     (host_rd_i),
    .wdata_i  (host_wdata_i),
    .ready_i  (ready),
    .idx_o    (idx_q),
    .ld_hi_o  (ld_hi),
    .ld_lo_o  (ld_lo),
    .data_wr_o(data_wr),
    .data_rd_o(data_rd)
  );

  // reads advance at once; writes advance when their slot completes
  vp_addr_ptr #(.DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_hi_i(ld_hi),
    .ld_lo_i(ld_lo),
    .inc_i  (data_rd || wr_done),
    .wdata_i(host_wdata_i),
    .ptr_o  (ptr)
  );

  vp_mem_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_wr_i (data_wr),
    .start_rd_i (ld_lo || data_rd),
    .wdata_i    (host_wdata_i),
    .mem_gnt_i  (mem_gnt_i),
    .mem_rdata_i(mem_rdata_i),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_wdata_o(mem_wdata_o),
    .ready_o    (ready),
    .wr_done_o  (wr_done),
    .rd_latch_o (rd_latch)
  );

  always_comb begin
    if (!host_sel_i) begin
      rd_mux = {ready, {PAD_W{1'b0}}, idx_q};
    end else begin
      unique case (int'(idx_q))
        IDX_PTR_HI: rd_mux = ptr[ADDR_W-1:DATA_W];
        IDX_PTR_LO: rd_mux = ptr[DATA_W-1:0];
        IDX_DATA:   rd_mux = rd_latch;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      rdata_q <= '0;
    else if (host_rd_i && !host_wr_i) rdata_q <= rd_mux;
  end

  assign host_rdata_o = rdata_q;
  assign mem_addr_o   = ptr;
endmodule

// File: rtl/vp_checker.sv
module vp_checker #(
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 5,
  parameter int MEM_DEPTH = 16384
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                host_sel_i,
  input logic                host_wr_i,
  input logic                host_rd_i,
  input logic [IDX_W-1:0]    idx_i,
  input logic                ready_i,
  input logic                mem_req_o,
  input logic                mem_we_o,
  input logic [2*DATA_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0]   mem_wdata_o,
  input logic                mem_gnt_i
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(MEM_DEPTH - 1);

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));

  // R9
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i |=> !mem_req_o);

  // R4
  lo_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && host_sel_i && ready_i && idx_i == IDX_W'(19) |=> mem_req_o && !mem_we_o);

  // R5
  data_rd_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && !host_wr_i && host_sel_i && ready_i && idx_i == IDX_W'(31)
    |=> mem_req_o && !mem_we_o);

  // R6 R7
  wr_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_gnt_i
    |=> mem_addr_o == (($past(mem_addr_o) >= LAST) ? '0 : $past(mem_addr_o) + 1'b1));

  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i && host_wr_i && host_sel_i && !mem_gnt_i |=> $stable(mem_addr_o));
endmodule

bind vram_port vp_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W), .MEM_DEPTH(MEM_DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .host_sel_i (host_sel_i),
  .host_wr_i  (host_wr_i),
  .host_rd_i  (host_rd_i),
  .idx_i      (idx_q),
  .ready_i    (ready),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_gnt_i  (mem_gnt_i)
);

// File: tb/tb_vram_port.sv
`timescale 1ns/1ps
module tb_vram_port;
  localparam int DEPTH = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        mem_req, mem_we, mem_gnt;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  vram_port #(.DATA_W(8), .IDX_W(5), .MEM_DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_sel_i(sel), .host_wr_i(wr), .host_rd_i(rd),
    .host_wdata_i(wdata), .host_rdata_o(rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // memory slot model
  logic [7:0] model [0:1023];
  int gnt_delay = 2;
  int wcnt = 0;
  logic        prev_wait = 1'b0;
  logic [15:0] prev_addr;
  logic [7:0]  prev_wd;
  logic        prev_we;

  initial for (int i = 0; i < 1024; i++) model[i] = pat(i);

  assign mem_gnt   = mem_req && (wcnt == gnt_delay);
  assign mem_rdata = model[mem_addr[9:0]];

  always @(posedge clk) begin
    if (mem_req && !mem_gnt) wcnt <= wcnt + 1;
    else                     wcnt <= 0;
    if (mem_req && mem_gnt && mem_we) model[mem_addr[9:0]] <= mem_wdata;
    if (prev_wait)  // R9: ungranted request must hold
      check(mem_req && mem_addr == prev_addr && mem_we == prev_we && mem_wdata == prev_wd,
            "R9 request hold", {mem_req, mem_addr}, {1'b1, prev_addr});
    prev_wait <= rst_n && mem_req && !mem_gnt;
    prev_addr <= mem_addr;
    prev_we   <= mem_we;
    prev_wd   <= mem_wdata;
  end

  // scoreboard
  typedef struct {
    logic [7:0] exp;
    bit         en;
    string      tag;
  } item_t;
  item_t q[$];
  logic       rd_seen = 1'b0;
  logic [7:0] last_rd;

  always @(posedge clk) rd_seen <= rd;

  always @(negedge clk) begin
    if (rd_seen && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      last_rd = rdata;
      if (it.en) check(rdata == it.exp, it.tag, rdata, it.exp);
    end
  end

  task automatic acc_wr(input logic s, input logic [7:0] d);
    sel = s; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0; #1;
  endtask

  task automatic acc_rd(input logic s, input bit en, input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.en = en; it.tag = tag;
    q.push_back(it);
    sel = s; rd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd = 1'b0; #1;
  endtask

  task automatic wait_ready();
    for (int n = 0; n < 64; n++) begin
      acc_rd(1'b0, 1'b0, 8'h00, "");
      if (last_rd[7]) return;
    end
  endtask

  task automatic set_ptr(input logic [15:0] a);
    acc_wr(1'b0, 8'd18); acc_wr(1'b1, a[15:8]);
    acc_wr(1'b0, 8'd19); acc_wr(1'b1, a[7:0]);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1..all act=timeout exp=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    acc_rd(1'b0, 1'b1, 8'h80, "R1 reset status");
    acc_wr(1'b0, 8'd18); acc_rd(1'b1, 1'b1, 8'h00, "R1 reset ptr hi");
    acc_wr(1'b0, 8'd19); acc_rd(1'b1, 1'b1, 8'h00, "R1 reset ptr lo");

    // R2 / R3 index and unmapped register
    acc_wr(1'b0, 8'h05);
    acc_rd(1'b0, 1'b1, 8'h85, "R2 status shows index");
    acc_wr(1'b1, 8'h77);
    acc_rd(1'b1, 1'b1, 8'h00, "R3 unmapped reads zero");
    acc_rd(1'b0, 1'b1, 8'h85, "R3 unmapped write no effect");

    // R4 low-byte write starts prefetch
    gnt_delay = 2;
    set_ptr(16'h0010);
    acc_rd(1'b0, 1'b1, 8'h13, "R4 ready low after lo write");
    wait_ready();
    acc_rd(1'b1, 1'b1, 8'h10, "R3 ptr lo readback");
    acc_wr(1'b0, 8'd18);
    acc_rd(1'b1, 1'b1, 8'h00, "R3 ptr hi readback");

    // R5 / R10 linear reads
    acc_wr(1'b0, 8'd31);
    for (int k = 0; k < 4; k++) begin
      acc_rd(1'b1, 1'b1, pat(16 + k), "R10 linear read");
      acc_rd(1'b0, 1'b1, 8'h1F, "R5 ready low after data read");
      wait_ready();
    end
    acc_wr(1'b0, 8'd19);
    acc_rd(1'b1, 1'b1, 8'h14, "R5 pointer advanced");

    // R6 writes, zero and nonzero grant latency
    gnt_delay = 0;
    acc_wr(1'b0, 8'd31);
    acc_wr(1'b1, 8'hA5); wait_ready();
    gnt_delay = 3;
    acc_wr(1'b1, 8'h5A);
    acc_rd(1'b0, 1'b1, 8'h1F, "R6 ready low during write");
    wait_ready();
    acc_wr(1'b0, 8'd19);
    acc_rd(1'b1, 1'b1, 8'h16, "R6 pointer after writes");
    set_ptr(16'h0014); wait_ready();
    acc_wr(1'b0, 8'd31);
    acc_rd(1'b1, 1'b1, 8'hA5, "R6 first byte written"); wait_ready();
    acc_rd(1'b1, 1'b1, 8'h5A, "R6 second byte written"); wait_ready();

    // R8 busy accesses ignored
    set_ptr(16'h0030);
    acc_wr(1'b1, 8'h40);  // busy: lo write dropped
    wait_ready();
    acc_rd(1'b1, 1'b1, 8'h30, "R8 lo write while busy ignored");
    acc_wr(1'b0, 8'd31);
    acc_rd(1'b1, 1'b1, pat(48), "R5 read at new pointer");
    acc_rd(1'b1, 1'b0, 8'h00, "");  // busy read
    wait_ready();
    acc_wr(1'b0, 8'd19);
    acc_rd(1'b1, 1'b1, 8'h31, "R8 read while busy no advance");
    acc_wr(1'b0, 8'd31);
    acc_wr(1'b1, 8'h11);
    acc_wr(1'b1, 8'h22);  // busy: dropped
    wait_ready();
    acc_wr(1'b0, 8'd19);
    acc_rd(1'b1, 1'b1, 8'h32, "R8 write while busy no advance");
    set_ptr(16'h0031); wait_ready();
    acc_wr(1'b0, 8'd31);
    acc_rd(1'b1, 1'b1, 8'h11, "R8 accepted write stored"); wait_ready();
    acc_rd(1'b1, 1'b1, pat(50), "R8 dropped write not stored"); wait_ready();

    // R7 wrap at MEM_DEPTH-1
    gnt_delay = 1;
    set_ptr(16'(DEPTH - 1)); wait_ready();
    acc_wr(1'b0, 8'd31);
    acc_rd(1'b1, 1'b1, pat(DEPTH - 1), "R7 read top address"); wait_ready();
    acc_wr(1'b0, 8'd18);
    acc_rd(1'b1, 1'b1, 8'h00, "R7 wrapped hi");
    acc_wr(1'b0, 8'd19);
    acc_rd(1'b1, 1'b1, 8'h00, "R7 wrapped lo");
    acc_wr(1'b0, 8'd31);
    acc_rd(1'b1, 1'b1, pat(0), "R7 read after wrap"); wait_ready();

    repeat (2) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule